// File: doc/BRIEF.md
# Banked Integer Register File with Zero and Stack-Pointer Aliasing

This block holds the 64-bit integer register state of a load/store processor core. It has two combinational read ports and one write port that stores on the rising clock edge. Indices 0 to 30 select ordinary general registers. Index 31 has no register behind it. Each port resolves it through its own mode flag, either to a hard zero or to the active stack pointer.

The stack pointer exists in four copies, one for each exception level 0 to 3. At level 0 the level-0 copy is always used. At higher levels a stack-select input picks between the level-0 copy and the copy that belongs to the current level.

Each port can also work on a 32-bit view of a register:
- A narrow write clears bits 63:32 of the destination.
- A narrow read returns the low half with the upper half forced to zero.

A read of the location being written in the same cycle sees the new value. No index maps to the program counter.

Top module: `banked_rf`

## Requirements
- R1: When wr_en_i is high and wr_idx_i is between 0 and 30, the general register with that index is updated at the rising clock edge. Either read port later returns the stored value at that index.
- R2: A read of index 31 with its port's sp-mode flag at 0 returns 0.
- R3: A write to index 31 with wr_sp_mode_i at 0 changes no general register and no stack pointer.
- R4: There are four stack-pointer copies, numbered by level 0 to 3. With the level input el_i equal to 0, index 31 in sp mode (flag 1) accesses copy 0 whatever sp_sel_i is.
- R5: With el_i above 0, index 31 in sp mode accesses copy 0 when sp_sel_i is 0, and copy el_i when sp_sel_i is 1.
- R6: The sp-mode flags of read port A, read port B and the write port act independently. In one cycle, one read port can see zero at index 31 while the other sees the stack pointer.
- R7: A write with wr_w32_i at 1 stores wr_data_i[31:0] in bits 31:0 and 0 in bits 63:32 of the target.
- R8: A read with its port's w32 flag at 1 returns bits 31:0 of the location with bits 63:32 at 0.
- R9: When a port reads the same location that the write port targets in that cycle, it returns the value being written. This applies to general registers and to stack-pointer copies. The written value has already been zero-extended when wr_w32_i is 1.
- R10: While rst_ni is low, every general register and every stack-pointer copy is cleared to 0.
- R11: The two read ports decode their index, mode and width inputs independently and return their results in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| el_i | input | 2 | Current exception level |
| sp_sel_i | input | 1 | Stack select above level 0 (1 = own copy) |
| rd_a_idx_i | input | 5 | Read port A index |
| rd_a_sp_mode_i | input | 1 | Port A: index 31 is stack pointer (1) or zero (0) |
| rd_a_w32_i | input | 1 | Port A 32-bit view |
| rd_a_data_o | output | 64 | Port A read data |
| rd_b_idx_i | input | 5 | Read port B index |
| rd_b_sp_mode_i | input | 1 | Port B: index 31 is stack pointer (1) or zero (0) |
| rd_b_w32_i | input | 1 | Port B 32-bit view |
| rd_b_data_o | output | 64 | Port B read data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write index |
| wr_sp_mode_i | input | 1 | Write: index 31 is stack pointer (1) or discarded (0) |
| wr_w32_i | input | 1 | 32-bit write with zero extension |
| wr_data_i | input | 64 | Write data |

## Verification
A wrong bank choice shows up as a stale or foreign stack-pointer value on a read port. It appears in the first cycle after the write that should have landed elsewhere. This happens whenever the level or select inputs change between the write and the read.

A missed zero-extension leaves old upper bits in place. A 64-bit read of the same register exposes them on the next cycle.

A broken bypass shows the old value in the same cycle as the write. The new value appears one cycle later, so a read-during-write check catches the fault at once. A discarded index-31 write that leaks into storage only shows up on a later read of a general register or stack-pointer copy. For that reason the bench reads all of them after such writes.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int XLEN_DEF  = 64;
  localparam int NGPR_DEF  = 31;
  localparam int NEL_DEF   = 4;
  localparam int IDX_W     = 5;
  localparam int EL_W      = 2;
  localparam logic [IDX_W-1:0] ALIAS_IDX = 5'd31;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_GPR  = 2'd1,
    TGT_SP   = 2'd2
  } tgt_kind_e;

  typedef struct packed {
    tgt_kind_e        kind;
    logic [IDX_W-1:0] gpr;
    logic [EL_W-1:0]  bank;
  } tgt_t;

  // Unused fields are held at zero so two targets compare as whole structs
  function automatic tgt_t resolve_tgt(
    input logic [IDX_W-1:0] idx,
    input logic             sp_mode,
    input logic [EL_W-1:0]  el,
    input logic             sp_sel
  );
    tgt_t t;
    t = '{kind: TGT_NONE, gpr: '0, bank: '0};
    if (idx != ALIAS_IDX) begin
      t.kind = TGT_GPR;
      t.gpr  = idx;
    end else if (sp_mode) begin
      t.kind = TGT_SP;
      t.bank = (el == '0 || !sp_sel) ? '0 : el;
    end
    return t;
  endfunction
endpackage

// File: rtl/rf_gpr_array.sv
module rf_gpr_array #(
  parameter int XLEN  = rf_pkg::XLEN_DEF,
  parameter int NREGS = rf_pkg::NGPR_DEF,
  localparam int IW   = rf_pkg::IDX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [IW-1:0]              widx_i,
  input  logic [XLEN-1:0]            wdata_i,
  output logic [NREGS-1:0][XLEN-1:0] regs_o
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_o[i] <= '0;
      else if (we_i && widx_i == IW'(i))        regs_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/rf_sp_bank.sv
module rf_sp_bank #(
  parameter int XLEN = rf_pkg::XLEN_DEF,
  parameter int NEL  = rf_pkg::NEL_DEF,
  localparam int EW  = rf_pkg::EL_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [EW-1:0]            wbank_i,
  input  logic [XLEN-1:0]          wdata_i,
  output logic [NEL-1:0][XLEN-1:0] sp_o
);
  for (genvar e = 0; e < NEL; e++) begin : g_sp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          sp_o[e] <= '0;
      else if (we_i && wbank_i == EW'(e))   sp_o[e] <= wdata_i;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int XLEN  = XLEN_DEF,
  parameter int NREGS = NGPR_DEF,
  parameter int NEL   = NEL_DEF,
  localparam int HALF = XLEN / 2
) (
  input  logic [IDX_W-1:0]           idx_i,
  input  logic                       sp_mode_i,
  input  logic                       w32_i,
  input  logic [EL_W-1:0]            el_i,
  input  logic                       sp_sel_i,
  input  logic [NREGS-1:0][XLEN-1:0] gpr_i,
  input  logic [NEL-1:0][XLEN-1:0]   sp_i,
  input  logic                       wr_en_i,
  input  tgt_t                       wr_tgt_i,
  input  logic [XLEN-1:0]            wr_val_i,
  output logic [XLEN-1:0]            data_o
);
  tgt_t            rd_tgt;
  logic            hit;
  logic [XLEN-1:0] stored;
  logic [XLEN-1:0] full;

  always_comb begin
    rd_tgt = resolve_tgt(idx_i, sp_mode_i, el_i, sp_sel_i);
    hit    = wr_en_i && (wr_tgt_i.kind != TGT_NONE) && (wr_tgt_i == rd_tgt);
    stored = '0;
    unique case (rd_tgt.kind)
      TGT_GPR: if (int'(rd_tgt.gpr) < NREGS) stored = gpr_i[rd_tgt.gpr];
      TGT_SP:  if (int'(rd_tgt.bank) < NEL)  stored = sp_i[rd_tgt.bank];
      default: stored = '0;
    endcase
    full   = hit ? wr_val_i : stored;
    data_o = w32_i ? {{(XLEN-HALF){1'b0}}, full[HALF-1:0]} : full;
  end
endmodule

// File: rtl/banked_rf.sv
module banked_rf
  import rf_pkg::*;
#(
  parameter int XLEN  = XLEN_DEF,
  parameter int NREGS = NGPR_DEF,
  parameter int NEL   = NEL_DEF,
  localparam int HALF = XLEN / 2,
  localparam int NRD  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EL_W-1:0]  el_i,
  input  logic             sp_sel_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic             rd_a_sp_mode_i,
  input  logic             rd_a_w32_i,
  output logic [XLEN-1:0]  rd_a_data_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  input  logic             rd_b_sp_mode_i,
  input  logic             rd_b_w32_i,
  output logic [XLEN-1:0]  rd_b_data_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_sp_mode_i,
  input  logic             wr_w32_i,
  input  logic [XLEN-1:0]  wr_data_i
);
  tgt_t                       wr_tgt;
  logic [XLEN-1:0]            wr_val;
  logic                       gpr_we, sp_we;
  logic [NREGS-1:0][XLEN-1:0] gpr_q;
  logic [NEL-1:0][XLEN-1:0]   sp_q;

  always_comb begin
    wr_tgt = resolve_tgt(wr_idx_i, wr_sp_mode_i, el_i, sp_sel_i);
    wr_val = wr_w32_i ? {{(XLEN-HALF){1'b0}}, wr_data_i[HALF-1:0]} : wr_data_i;
    gpr_we = wr_en_i && wr_tgt.kind == TGT_GPR;
    sp_we  = wr_en_i && wr_tgt.kind == TGT_SP;
  end

  rf_gpr_array #(.XLEN(XLEN), .NREGS(NREGS)) i_gpr (
    .clk_i, .rst_ni,
    .we_i(gpr_we), .widx_i(wr_tgt.gpr), .wdata_i(wr_val), .regs_o(gpr_q)
  );

  rf_sp_bank #(.XLEN(XLEN), .NEL(NEL)) i_sp (
    .clk_i, .rst_ni,
    .we_i(sp_we), .wbank_i(wr_tgt.bank), .wdata_i(wr_val), .sp_o(sp_q)
  );

  logic [NRD-1:0][IDX_W-1:0] rd_idx;
  logic [NRD-1:0]            rd_spm, rd_w32;
  logic [NRD-1:0][XLEN-1:0]  rd_data;

  assign rd_idx = {rd_b_idx_i, rd_a_idx_i};
  assign rd_spm = {rd_b_sp_mode_i, rd_a_sp_mode_i};
  assign rd_w32 = {rd_b_w32_i, rd_a_w32_i};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_read_port #(.XLEN(XLEN), .NREGS(NREGS), .NEL(NEL)) i_port (
      .idx_i(rd_idx[p]), .sp_mode_i(rd_spm[p]), .w32_i(rd_w32[p]),
      .el_i, .sp_sel_i,
      .gpr_i(gpr_q), .sp_i(sp_q),
      .wr_en_i, .wr_tgt_i(wr_tgt), .wr_val_i(wr_val),
      .data_o(rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
endmodule

// File: rtl/banked_rf_chk.sv
module banked_rf_chk
  import rf_pkg::*;
#(
  parameter int XLEN = XLEN_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [EL_W-1:0]  el_i,
  input logic             sp_sel_i,
  input logic [IDX_W-1:0] rd_a_idx_i,
  input logic             rd_a_sp_mode_i,
  input logic             rd_a_w32_i,
  input logic [XLEN-1:0]  rd_a_data_o,
  input logic [IDX_W-1:0] rd_b_idx_i,
  input logic             rd_b_sp_mode_i,
  input logic             rd_b_w32_i,
  input logic [XLEN-1:0]  rd_b_data_o,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic             wr_sp_mode_i,
  input logic             wr_w32_i,
  input logic [XLEN-1:0]  wr_data_i
);
  localparam int HALF = XLEN / 2;

  logic a_uses_sp0, w_uses_sp0;
  assign a_uses_sp0 = (el_i == '0) || !sp_sel_i;
  assign w_uses_sp0 = (el_i == '0) || !sp_sel_i;

  // R2
  a_r2_zero_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_b_idx_i == ALIAS_IDX && !rd_b_sp_mode_i) |-> rd_b_data_o == '0);

  // R8
  a_r8_narrow_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_w32_i |-> rd_a_data_o[XLEN-1:HALF] == '0);

  // R9
  a_r9_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i != ALIAS_IDX && !wr_w32_i &&
     rd_a_idx_i == wr_idx_i && !rd_a_w32_i) |-> rd_a_data_o == wr_data_i);

  // R1
  a_r1_write_then_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i && wr_idx_i != ALIAS_IDX && !wr_w32_i) &&
     rd_b_idx_i == $past(wr_idx_i) && !rd_b_w32_i && !wr_en_i)
    |-> rd_b_data_o == $past(wr_data_i));

  // R7
  a_r7_narrow_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i && wr_idx_i != ALIAS_IDX && wr_w32_i) &&
     rd_a_idx_i == $past(wr_idx_i) && !wr_en_i)
    |-> rd_a_data_o[XLEN-1:HALF] == '0);

  // R4, R5
  a_r4_sp0_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i && wr_idx_i == ALIAS_IDX && wr_sp_mode_i &&
                            !wr_w32_i && w_uses_sp0) &&
     rd_a_idx_i == ALIAS_IDX && rd_a_sp_mode_i && !rd_a_w32_i &&
     a_uses_sp0 && !wr_en_i)
    |-> rd_a_data_o == $past(wr_data_i));
endmodule

bind banked_rf banked_rf_chk #(.XLEN(XLEN)) i_banked_rf_chk (.*);

// File: tb/test_banked_rf.sv
`timescale 1ns/1ps
module test_banked_rf;
  localparam int XLEN = 64;

  logic            clk = 0, rst_ni = 0;
  logic [1:0]      el = 0;
  logic            sp_sel = 0;
  logic [4:0]      ra_idx = 0, rb_idx = 0, w_idx = 0;
  logic            ra_spm = 0, rb_spm = 0, ra_w32 = 0, rb_w32 = 0;
  logic            w_en = 0, w_spm = 0, w_w32 = 0;
  logic [XLEN-1:0] w_data = 0;
  logic [XLEN-1:0] ra_data, rb_data;

  logic [XLEN-1:0] m_gpr [31];
  logic [XLEN-1:0] m_sp  [4];
  int n_tests = 0, n_fail = 0;

  always #10 clk = ~clk;

  banked_rf i_banked_rf (
    .clk_i(clk), .rst_ni, .el_i(el), .sp_sel_i(sp_sel),
    .rd_a_idx_i(ra_idx), .rd_a_sp_mode_i(ra_spm), .rd_a_w32_i(ra_w32), .rd_a_data_o(ra_data),
    .rd_b_idx_i(rb_idx), .rd_b_sp_mode_i(rb_spm), .rd_b_w32_i(rb_w32), .rd_b_data_o(rb_data),
    .wr_en_i(w_en), .wr_idx_i(w_idx), .wr_sp_mode_i(w_spm), .wr_w32_i(w_w32), .wr_data_i(w_data)
  );

  // -1: none, 0..30 general, 100+n stack copy n
  function automatic int loc(input logic [4:0] idx, input logic spm);
    if (idx != 31) return int'(idx);
    if (!spm) return -1;
    if (el == 0 || !sp_sel) return 100;
    return 100 + int'(el);
  endfunction

  function automatic logic [XLEN-1:0] wval();
    return w_w32 ? {32'h0, w_data[31:0]} : w_data;
  endfunction

  function automatic logic [XLEN-1:0] exp_rd(input logic [4:0] idx, input logic spm, input logic w32);
    int l;
    logic [XLEN-1:0] v;
    l = loc(idx, spm);
    if (l < 0) v = '0;
    else if (w_en && l == loc(w_idx, w_spm)) v = wval();
    else if (l >= 100) v = m_sp[l-100];
    else v = m_gpr[l];
    return w32 ? {32'h0, v[31:0]} : v;
  endfunction

  function automatic string tag_of(input logic [4:0] idx, input logic spm, input logic w32);
    int l;
    l = loc(idx, spm);
    if (l >= 0 && w_en && l == loc(w_idx, w_spm)) return "R9";
    if (l < 0) return "R2";
    if (w32) return "R8";
    if (l >= 100) return (el == 0) ? "R4" : "R5";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check mid-low phase, commit model after the edge
  task automatic step(input string ta = "", input string tb = "");
    #2;
    check(ta == "" ? tag_of(ra_idx, ra_spm, ra_w32) : ta, ra_data, exp_rd(ra_idx, ra_spm, ra_w32));
    check(tb == "" ? tag_of(rb_idx, rb_spm, rb_w32) : tb, rb_data, exp_rd(rb_idx, rb_spm, rb_w32));
    @(posedge clk);
    if (w_en) begin
      int l;
      l = loc(w_idx, w_spm);
      if (l >= 100) m_sp[l-100] = wval();
      else if (l >= 0) m_gpr[l] = wval();
    end
    @(negedge clk);
  endtask

  task automatic set_wr(input logic en, input logic [4:0] idx, input logic spm, input logic w32, input logic [XLEN-1:0] d);
    w_en = en; w_idx = idx; w_spm = spm; w_w32 = w32; w_data = d;
  endtask

  task automatic set_rd(input logic [4:0] ai, input logic as, input logic aw,
                        input logic [4:0] bi, input logic bs, input logic bw);
    ra_idx = ai; ra_spm = as; ra_w32 = aw; rb_idx = bi; rb_spm = bs; rb_w32 = bw;
  endtask

  task automatic sweep_all(input string req);
    set_wr(0, 0, 0, 0, 0);
    for (int i = 0; i < 31; i++) begin
      set_rd(5'(i), 0, 0, 5'(30 - i), 0, 0);
      step(req, req);
    end
    for (int e = 0; e < 4; e++) begin
      el = 2'(e); sp_sel = 1;
      set_rd(31, 1, 0, 31, 1, 0);
      step(req, req);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < 31; i++) m_gpr[i] = '0;
    for (int i = 0; i < 4; i++) m_sp[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R10: all state cleared by reset
    sweep_all("R10");

    // R3: zero-mode write to 31 is dropped everywhere
    el = 2; sp_sel = 1;
    set_wr(1, 31, 0, 0, 64'hDEAD_BEEF_1234_5678);
    set_rd(31, 1, 0, 31, 0, 0);
    step("R3", "R2");
    sweep_all("R3");

    // R4: level 0 ignores sp_sel
    el = 0; sp_sel = 1;
    set_wr(1, 31, 1, 0, 64'h0000_00AA_0000_0001);
    set_rd(31, 1, 0, 31, 1, 0);
    step("R9", "R9");
    set_wr(0, 0, 0, 0, 0);
    el = 0; sp_sel = 0; set_rd(31, 1, 0, 31, 1, 0); step("R4", "R4");
    el = 3; sp_sel = 1; set_rd(31, 1, 0, 31, 1, 0); step("R5", "R5");

    // R5: own copy per level, copy 0 when select is 0
    for (int e = 1; e < 4; e++) begin
      el = 2'(e); sp_sel = 1;
      set_wr(1, 31, 1, 0, 64'h1111_0000_0000_0000 * e + 64'(e));
      set_rd(0, 0, 0, 1, 0, 0);
      step("R1", "R1");
    end
    set_wr(0, 0, 0, 0, 0);
    for (int e = 1; e < 4; e++) begin
      el = 2'(e);
      sp_sel = 1; set_rd(31, 1, 0, 31, 1, 0); step("R5", "R5");
      sp_sel = 0; set_rd(31, 1, 0, 31, 1, 0); step("R5", "R5");
    end

    // R6: independent mode flags in one cycle
    el = 2; sp_sel = 1;
    set_rd(31, 0, 0, 31, 1, 0); step("R6", "R6");
    set_wr(1, 31, 0, 0, 64'h5); set_rd(31, 1, 0, 31, 0, 0); step("R6", "R6");
    set_wr(0, 0, 0, 0, 0);      set_rd(31, 1, 0, 31, 1, 0); step("R6", "R6");

    // R7: narrow write clears upper half
    set_wr(1, 7, 0, 0, '1); set_rd(0, 0, 0, 0, 0, 0); step("R1", "R1");
    set_wr(1, 7, 0, 1, 64'hFFFF_FFFF_8765_4321); set_rd(7, 0, 0, 7, 0, 1); step("R9", "R9");
    set_wr(0, 0, 0, 0, 0); set_rd(7, 0, 0, 7, 0, 1); step("R7", "R8");
    set_wr(1, 31, 1, 1, 64'hABCD_0000_FFFF_0001); set_rd(2, 0, 0, 3, 0, 0); step("R1", "R1");
    set_wr(0, 0, 0, 0, 0); set_rd(31, 1, 0, 31, 1, 0); step("R7", "R7");

    // R11: different locations on the two ports
    set_wr(1, 12, 0, 0, 64'h0123_4567_89AB_CDEF); set_rd(0, 0, 0, 0, 0, 0); step("R11", "R11");
    set_wr(0, 0, 0, 0, 0); set_rd(12, 0, 0, 31, 1, 0); step("R11", "R11");
    set_rd(31, 0, 0, 12, 0, 1); step("R11", "R11");

    // random mix, biased toward index 31 and write/read overlap
    for (int n = 0; n < 3000; n++) begin
      el = 2'($urandom); sp_sel = 1'($urandom);
      w_en = ($urandom % 4) != 0;
      w_idx = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom % 32);
      w_spm = 1'($urandom); w_w32 = ($urandom % 4) == 0;
      w_data = {$urandom, $urandom};
      ra_idx = ($urandom % 4 == 0) ? w_idx : 5'($urandom % 32);
      rb_idx = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom % 32);
      ra_spm = 1'($urandom); rb_spm = 1'($urandom);
      ra_w32 = ($urandom % 4) == 0; rb_w32 = ($urandom % 4) == 0;
      step();
    end

    sweep_all("R3");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule